// File: doc/BRIEF.md
# Receive Byte Queue with Line-Break Insertion

This block is a small first-in first-out store that sits between a serial receiver and the host register port of a UART. The receiver hands it bytes, and also line-break events, which enter the data stream as a zero byte. The register side reads the oldest byte through a combinational output and takes it away with a pop strobe. The block keeps three flags: data available, queue full, and break seen.

The receiver is throttled by a ready output. This output is high only while the receiver is enabled and the queue is not full. If the receiver writes while the queue is full, the newest stored byte is replaced and the queue does not grow. When data and a break arrive together, the break takes precedence. A synchronous flush input serves the receiver-reset command. The break flag stays set until the register side clears it with a strobe.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset the queue is empty, all three flags are low and `pop_data` reads 0x00.
- R2: Bytes leave in arrival order. `pop_data` always shows the oldest held byte, and a pop moves the remaining bytes one place towards the output.
- R3: A pop while the queue is empty changes nothing, and `pop_data` reads 0x00 while the queue is empty.
- R4: Any write (data or break) sets `avail_flag` in the next cycle. A pop clears `avail_flag` only when it removes the last held byte.
- R5: `full_flag` rises on the write that brings the count to DEPTH (4). A pop with no write in the same cycle clears it.
- R6: A write while DEPTH bytes are held and no pop occurs replaces the newest byte. The count stays at DEPTH and the older bytes are untouched.
- R7: A break event stores 0x00 as a byte and sets `brk_flag`. If `push_valid` and `brk_evt` are both high in the same cycle, only the 0x00 is stored.
- R8: `rx_ready` is high only while `rx_en` is high and `full_flag` is low.
- R9: `flush` empties the queue and clears `avail_flag` and `full_flag` in the next cycle. It overrides any write or pop in the same cycle, but a break in that cycle still sets `brk_flag`.
- R10: When a pop and a write occur in the same cycle, the pop is applied first and then the write. At a full queue this keeps the count at DEPTH with `full_flag` high, and the written byte becomes the newest entry.
- R11: `brk_flag` is cleared only by `brk_clr`. A break in the same cycle as `brk_clr` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enabled |
| push_valid | input | 1 | Received data byte is valid |
| push_data | input | WIDTH | Received data byte |
| brk_evt | input | 1 | Line break detected |
| rx_ready | output | 1 | Queue can accept from the receiver |
| pop | input | 1 | Remove the oldest byte |
| pop_data | output | WIDTH | Oldest byte, or 0x00 when empty |
| flush | input | 1 | Synchronous empty (receiver reset) |
| brk_clr | input | 1 | Clear the break flag |
| avail_flag | output | 1 | At least one byte held |
| full_flag | output | 1 | DEPTH bytes held |
| brk_flag | output | 1 | Break seen since the last clear |

## Verification
A wrong count or a wrong write slot shows up on `pop_data` at once. It appears as a byte out of order, as a lost byte, or as a stale byte read after the queue should be empty, and it is visible no later than the pop that reaches the damaged slot. A wrong full state shows up in the same cycle on `rx_ready`. A wrong available state shows up as a zero byte on `pop_data` while bytes are still held. The directed scenarios therefore fill and drain the queue completely, so that every slot is read back through `pop_data`.

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  input  logic             brk_evt,
  output logic             rx_ready,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  input  logic             flush,
  input  logic             brk_clr,
  output logic             avail_flag,
  output logic             full_flag,
  output logic             brk_flag
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] q     [DEPTH];
  logic [WIDTH-1:0] q_nxt [DEPTH];
  logic [CW-1:0]    cnt, cnt_pop, cnt_nxt;
  logic [AW-1:0]    slot;

  wire             do_push = push_valid | brk_evt;
  wire [WIDTH-1:0] in_byte = brk_evt ? '0 : push_data;
  wire             do_pop  = pop & (cnt != '0);
  wire             at_cap  = (cnt_pop == CW'(DEPTH));

  assign cnt_pop = cnt - CW'(do_pop);
  assign slot    = at_cap ? AW'(DEPTH - 1) : cnt_pop[AW-1:0];
  assign cnt_nxt = flush ? '0 : (do_push && !at_cap) ? cnt_pop + CW'(1) : cnt_pop;

  always_comb begin
    for (int i = 0; i < DEPTH - 1; i++) q_nxt[i] = do_pop ? q[i+1] : q[i];
    q_nxt[DEPTH-1] = q[DEPTH-1];
    if (do_push) q_nxt[slot] = in_byte;
  end

  always_ff @(posedge clk) begin
    if (!flush) q <= q_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      avail_flag <= 1'b0;
      full_flag  <= 1'b0;
      brk_flag   <= 1'b0;
    end else begin
      cnt        <= cnt_nxt;
      avail_flag <= cnt_nxt != '0;
      full_flag  <= cnt_nxt == CW'(DEPTH);
      if (brk_evt)      brk_flag <= 1'b1;
      else if (brk_clr) brk_flag <= 1'b0;
    end
  end

  assign pop_data = (cnt == '0) ? '0 : q[0];
  assign rx_ready = rx_en & ~full_flag;
endmodule

module rx_byte_queue_chk #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en,
  input logic             push_valid,
  input logic [WIDTH-1:0] push_data,
  input logic             brk_evt,
  input logic             rx_ready,
  input logic             pop,
  input logic [WIDTH-1:0] pop_data,
  input logic             flush,
  input logic             brk_clr,
  input logic             avail_flag,
  input logic             full_flag,
  input logic             brk_flag
);
  p_empty_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !avail_flag |-> pop_data == '0);
  p_full_avail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full_flag |-> avail_flag);
  p_pop_clears_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push_valid && !brk_evt |=> !full_flag);
  p_write_avail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid || brk_evt) && !flush |=> avail_flag);
  p_break_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt && !avail_flag && !flush |=> pop_data == '0 && avail_flag && brk_flag);
  p_ready_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_en && !full_flag);
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !avail_flag && !full_flag);
  p_full_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full_flag && pop && push_valid && !flush |=> full_flag);
  p_brk_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag && !brk_clr |=> brk_flag);
  p_brk_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_flag);
endmodule

bind rx_byte_queue rx_byte_queue_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/rx_byte_queue_tb.sv
module rx_byte_queue_tb;
  logic       clk = 0, rst_n = 0, rx_en = 0, push_valid = 0, brk_evt = 0;
  logic       pop = 0, flush = 0, brk_clr = 0;
  logic [7:0] push_data = 0;
  logic [7:0] pop_data;
  logic       rx_ready, avail_flag, full_flag, brk_flag;
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  rx_byte_queue u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    push_valid = 0; brk_evt = 0; pop = 0; flush = 0; brk_clr = 0;
  endtask

  task automatic put(logic [7:0] d);
    push_valid = 1; push_data = d; step();
  endtask

  task automatic take(string req, logic [7:0] exp);
    check(req, pop_data, exp); pop = 1; step();
  endtask

  task automatic t_reset();
    check("R1 avail", avail_flag, 0); check("R1 full", full_flag, 0);
    check("R1 brk", brk_flag, 0); check("R1 data", pop_data, 0);
    check("R8 disabled", rx_ready, 0);
    rx_en = 1; #0.5; check("R8 enabled", rx_ready, 1);
  endtask

  task automatic t_order();
    put(8'hA1); check("R4 avail", avail_flag, 1);
    put(8'hB2); put(8'hC3);
    take("R2 first", 8'hA1); check("R4 stays", avail_flag, 1);
    take("R2 second", 8'hB2); take("R2 third", 8'hC3);
    check("R4 cleared", avail_flag, 0); check("R3 empty data", pop_data, 0);
  endtask

  task automatic t_empty_pop();
    pop = 1; step();
    check("R3 avail", avail_flag, 0); check("R3 data", pop_data, 0);
    put(8'h55); check("R3 after", pop_data, 8'h55);
    take("R3 drain", 8'h55);
  endtask

  task automatic t_full();
    put(8'h01); put(8'h02); put(8'h03);
    check("R5 not yet", full_flag, 0);
    put(8'h04);
    check("R5 full", full_flag, 1); check("R8 throttle", rx_ready, 0);
    put(8'h99);
    check("R6 full kept", full_flag, 1); check("R6 head", pop_data, 8'h01);
    take("R6 d1", 8'h01); check("R5 pop clears", full_flag, 0);
    check("R8 reopen", rx_ready, 1);
    take("R6 d2", 8'h02); take("R6 d3", 8'h03); take("R6 newest", 8'h99);
    check("R6 empty", avail_flag, 0);
  endtask

  task automatic t_break();
    put(8'h11);
    brk_evt = 1; push_valid = 1; push_data = 8'h77; step();
    check("R7 flag", brk_flag, 1);
    take("R7 data", 8'h11); take("R7 zero", 8'h00);
    check("R7 only one", avail_flag, 0);
    repeat (3) step();
    check("R11 hold", brk_flag, 1);
    brk_clr = 1; step(); check("R11 clear", brk_flag, 0);
    brk_clr = 1; brk_evt = 1; step(); check("R11 set wins", brk_flag, 1);
    take("R11 zero", 8'h00);
    brk_clr = 1; step();
    put(8'h21); put(8'h22); put(8'h23); put(8'h24);
    brk_evt = 1; step();
    check("R7 full kept", full_flag, 1);
    take("R7 f1", 8'h21); take("R7 f2", 8'h22); take("R7 f3", 8'h23);
    take("R7 newest zero", 8'h00); check("R7 drained", avail_flag, 0);
    brk_clr = 1; step();
  endtask

  task automatic t_flush();
    put(8'h31); put(8'h32); put(8'h33); put(8'h34);
    flush = 1; push_valid = 1; push_data = 8'h40; pop = 1; step();
    check("R9 avail", avail_flag, 0); check("R9 full", full_flag, 0);
    check("R9 data", pop_data, 0); check("R9 brk untouched", brk_flag, 0);
    flush = 1; brk_evt = 1; step();
    check("R9 brk set", brk_flag, 1); check("R9 no store", avail_flag, 0);
    put(8'h35); take("R9 fresh", 8'h35);
    brk_clr = 1; step();
  endtask

  task automatic t_simul();
    push_valid = 1; push_data = 8'h61; pop = 1; step();
    check("R10 empty push", avail_flag, 1); check("R10 empty data", pop_data, 8'h61);
    put(8'h62); put(8'h63); put(8'h64);
    check("R10 full", full_flag, 1);
    push_valid = 1; push_data = 8'h65; pop = 1; step();
    check("R10 full stays", full_flag, 1); check("R10 head", pop_data, 8'h62);
    take("R10 b", 8'h62); take("R10 c", 8'h63);
    take("R10 d", 8'h64); take("R10 new", 8'h65);
    check("R10 drained", avail_flag, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1; #1;
    t_reset(); t_order(); t_empty_pop(); t_full();
    t_break(); t_flush(); t_simul();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule